// File: doc/BRIEF.md
# Secure Seconds Counter with Alarm

This block keeps wall-clock time as a 32-bit count of seconds plus a sub-second count of ticks. A slow tick-enable pulse, nominally 32768 per second and synchronous to the bus clock, drives the sub-second counter. Each full wrap of that counter adds one second. A 32-bit alarm value and a sub-second alarm value are compared against the running time. A match raises a sticky alarm flag.

Software reaches the block over a simple register bus with separate read and write strobes, a 3-bit word offset and 32-bit data. Writes to the time, alarm and control registers are not applied at once. Each one is held in a single pending slot and lands on the fourth tick pulse, and the status register tracks busy, completion and refusal. Sticky lock bits in the control register keep software from moving the time or from starting and stopping it. A security-violation input sets a sticky flag. One level interrupt output combines the enabled flags.

Top module: `sec_rtc_core`

## Requirements
- R1: Word offsets map as follows: 0 seconds, 1 sub-second count (low FRAC_W bits, upper bits zero), 2 alarm seconds, 3 alarm sub-second, 4 control, 5 status, 6 interrupt enable, and 7 reads zero. Read data appears on the cycle after the read strobe. After reset every register reads zero except alarm seconds, which reads 0xFFFFFFFF.
- R2: A write to offsets 0 to 4 is deferred. Status bit 10 (busy) reads 1 from the cycle after the write until the fourth tick pulse, and the new value is applied at that fourth pulse. Writes to offsets 5 and 6 take effect on the next clock edge and do not start the busy period.
- R3: Time advances only while control bit 3 (run) is 1. Each tick pulse adds one to the sub-second count. When that count wraps from 2^FRAC_W-1 to 0, the seconds count increments.
- R4: When the seconds count wraps from 0xFFFFFFFF to 0, status bit 2 (overflow) is set.
- R5: Status bit 4 (alarm) is set on the advance at which the seconds count equals the alarm seconds and the sub-second count equals the low FRAC_W bits of the alarm sub-second register. An alarm seconds value of 0xFFFFFFFF disables the alarm.
- R6: Each deferred write that lands sets status bit 8 (write complete) and status bit 9 (no longer busy).
- R7: A deferred write issued while busy is discarded and sets status bit 7 (write error).
- R8: Writing 1 to status bit 0, 2, 4, 7, 8 or 9 clears that flag. A flag that is set on the same edge stays set.
- R9: Control bits 17 and 18 are locks. Once written as 1 they stay 1 until reset. While either lock is 1, a write to offset 0 or 1, or a control write that changes bit 3, is refused at once: status bit 7 is set and busy does not start.
- R10: A high level on viol_in sets status bit 0 (security violation).
- R11: irq is high whenever any status bit 0, 4, 8 or 9 is 1 and the interrupt-enable bit at the same position is 1. Only those four enable bits are stored.
- R12: A write that lands on offset 0 or 1 replaces the time, and the sub-second count does not advance on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Slow tick pulse, one clock cycle wide |
| viol_in | input | 1 | Security violation indication |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Combined interrupt |

## Verification
The bench runs a small sub-second width of 3 bits and sweeps the time tick by tick through the sub-second wrap and the 32-bit seconds wrap, computing each expected value arithmetically. A design that mishandled the carry would show a wrong second at every eighth tick. A design that compared the alarm against all ones would raise the alarm when the count passes 0xFFFFFFFF.

Three cases cover the write path. A write issued during busy must not overwrite the alarm value that was already pending. A commit of the seconds count must freeze the sub-second count on that tick, and an off-by-one in the delay shows up as a value that lands on the third or fifth pulse. Writes under a lock must be refused without starting busy, and the lock bits must stay set after a write of zero.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    typedef enum logic [2:0] {
        A_SEC    = 3'd0,
        A_FRAC   = 3'd1,
        A_ALMSEC = 3'd2,
        A_ALMLO  = 3'd3,
        A_CTRL   = 3'd4,
        A_STAT   = 3'd5,
        A_IEN    = 3'd6
    } reg_addr_e;

    localparam int C_RUN   = 3;
    localparam int C_SLOCK = 17;
    localparam int C_HLOCK = 18;

    localparam int S_VIOL  = 0;
    localparam int S_OVF   = 2;
    localparam int S_ALM   = 4;
    localparam int S_WERR  = 7;
    localparam int S_WDONE = 8;
    localparam int S_WIDLE = 9;
    localparam int S_BUSY  = 10;

    localparam logic [31:0] IEN_MASK = 32'h0000_0311;

    typedef struct packed {
        logic [2:0]  addr;
        logic [31:0] data;
    } wr_req_t;

    typedef struct packed {
        logic viol;
        logic ovf;
        logic alm;
        logic werr;
        logic wdone;
        logic widle;
    } flags_t;

    function automatic logic is_deferred(input logic [2:0] a);
        return a <= A_CTRL;
    endfunction

    function automatic logic [31:0] pack_status(input flags_t f, input logic busy);
        logic [31:0] s;
        s = '0;
        s[S_VIOL]  = f.viol;
        s[S_OVF]   = f.ovf;
        s[S_ALM]   = f.alm;
        s[S_WERR]  = f.werr;
        s[S_WDONE] = f.wdone;
        s[S_WIDLE] = f.widle;
        s[S_BUSY]  = busy;
        return s;
    endfunction

endpackage

// File: rtl/sec_rtc_timebase.sv
module sec_rtc_timebase #(
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              run,
    input  logic              ld_sec,
    input  logic              ld_frac,
    input  logic [31:0]       ld_data,
    input  logic [31:0]       alm_sec,
    input  logic [FRAC_W-1:0] alm_frac,
    output logic [31:0]       sec_q,
    output logic [FRAC_W-1:0] frac_q,
    output logic              wrap_p,
    output logic              hit_p
);
    localparam logic [FRAC_W-1:0] FRAC_MAX = '1;
    localparam logic [31:0]       SEC_MAX  = '1;

    logic              adv;
    logic              carry;
    logic [FRAC_W-1:0] frac_n;
    logic [31:0]       sec_n;

    always_comb begin
        adv    = tick_en && run && !ld_sec && !ld_frac;
        carry  = (frac_q == FRAC_MAX);
        frac_n = frac_q + 1'b1;
        sec_n  = carry ? sec_q + 32'd1 : sec_q;
        wrap_p = adv && carry && (sec_q == SEC_MAX);
        hit_p  = adv && (alm_sec != SEC_MAX) && (sec_n == alm_sec) && (frac_n == alm_frac);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q  <= '0;
            frac_q <= '0;
        end else if (ld_sec) begin
            sec_q  <= ld_data;
        end else if (ld_frac) begin
            frac_q <= ld_data[FRAC_W-1:0];
        end else if (adv) begin
            sec_q  <= sec_n;
            frac_q <= frac_n;
        end
    end
endmodule

// File: rtl/sec_rtc_wcommit.sv
module sec_rtc_wcommit
    import sec_rtc_pkg::*;
#(
    parameter int BUSY_TICKS = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick_en,
    input  logic    accept,
    input  wr_req_t req_in,
    output logic    busy,
    output logic    commit,
    output wr_req_t req_q
);
    localparam int CNT_W = $clog2(BUSY_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    assign commit = busy && tick_en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            req_q <= '0;
        end else if (accept && !busy) begin
            busy  <= 1'b1;
            cnt   <= '0;
            req_q <= req_in;
        end else if (busy && tick_en) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sec_rtc_core.sv
module sec_rtc_core
    import sec_rtc_pkg::*;
#(
    parameter int FRAC_W     = 15,
    parameter int BUSY_TICKS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        viol_in,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);
    logic              ctl_run, ctl_slock, ctl_hlock, lock_any;
    logic [31:0]       alm_sec_q, alm_lo_q, ien_q;
    flags_t            flg;
    logic              busy, commit, accept, wr_err, lock_hit, deferred;
    wr_req_t           req_in, req_q;
    logic [31:0]       sec_q;
    logic [FRAC_W-1:0] frac_q;
    logic              wrap_p, hit_p;
    logic              c_sec, c_frac, c_almsec, c_almlo, c_ctrl;
    logic              stat_wr;
    logic [31:0]       stat_word, ctrl_word;

    assign lock_any = ctl_slock || ctl_hlock;
    assign deferred = wr_en && is_deferred(addr);
    assign lock_hit = lock_any && ((addr == A_SEC) || (addr == A_FRAC) ||
                      ((addr == A_CTRL) && (wdata[C_RUN] != ctl_run)));
    assign wr_err   = deferred && (busy || lock_hit);
    assign accept   = deferred && !wr_err;
    assign req_in   = '{addr: addr, data: wdata};

    sec_rtc_wcommit #(.BUSY_TICKS(BUSY_TICKS)) u_wcommit (
        .clk(clk), .rst(rst), .tick_en(tick_en), .accept(accept),
        .req_in(req_in), .busy(busy), .commit(commit), .req_q(req_q)
    );

    assign c_sec    = commit && (req_q.addr == A_SEC);
    assign c_frac   = commit && (req_q.addr == A_FRAC);
    assign c_almsec = commit && (req_q.addr == A_ALMSEC);
    assign c_almlo  = commit && (req_q.addr == A_ALMLO);
    assign c_ctrl   = commit && (req_q.addr == A_CTRL);

    sec_rtc_timebase #(.FRAC_W(FRAC_W)) u_timebase (
        .clk(clk), .rst(rst), .tick_en(tick_en), .run(ctl_run),
        .ld_sec(c_sec), .ld_frac(c_frac), .ld_data(req_q.data),
        .alm_sec(alm_sec_q), .alm_frac(alm_lo_q[FRAC_W-1:0]),
        .sec_q(sec_q), .frac_q(frac_q), .wrap_p(wrap_p), .hit_p(hit_p)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_run   <= 1'b0;
            ctl_slock <= 1'b0;
            ctl_hlock <= 1'b0;
            alm_sec_q <= '1;
            alm_lo_q  <= '0;
            ien_q     <= '0;
        end else begin
            if (c_ctrl) begin
                ctl_run   <= req_q.data[C_RUN];
                ctl_slock <= ctl_slock | req_q.data[C_SLOCK];
                ctl_hlock <= ctl_hlock | req_q.data[C_HLOCK];
            end
            if (c_almsec) alm_sec_q <= req_q.data;
            if (c_almlo)  alm_lo_q  <= req_q.data;
            if (wr_en && (addr == A_IEN)) ien_q <= wdata & IEN_MASK;
        end
    end

    assign stat_wr = wr_en && (addr == A_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            flg <= '0;
        end else begin
            flg.viol  <= (flg.viol  && !(stat_wr && wdata[S_VIOL]))  || viol_in;
            flg.ovf   <= (flg.ovf   && !(stat_wr && wdata[S_OVF]))   || wrap_p;
            flg.alm   <= (flg.alm   && !(stat_wr && wdata[S_ALM]))   || hit_p;
            flg.werr  <= (flg.werr  && !(stat_wr && wdata[S_WERR]))  || wr_err;
            flg.wdone <= (flg.wdone && !(stat_wr && wdata[S_WDONE])) || commit;
            flg.widle <= (flg.widle && !(stat_wr && wdata[S_WIDLE])) || commit;
        end
    end

    always_comb begin
        stat_word = pack_status(flg, busy);
        ctrl_word = '0;
        ctrl_word[C_RUN]   = ctl_run;
        ctrl_word[C_SLOCK] = ctl_slock;
        ctrl_word[C_HLOCK] = ctl_hlock;
    end

    assign irq = |(stat_word & ien_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                A_SEC:    rdata <= sec_q;
                A_FRAC:   rdata <= 32'(frac_q);
                A_ALMSEC: rdata <= alm_sec_q;
                A_ALMLO:  rdata <= alm_lo_q;
                A_CTRL:   rdata <= ctrl_word;
                A_STAT:   rdata <= stat_word;
                A_IEN:    rdata <= ien_q;
                default:  rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/sec_rtc_core_chk.sv
module sec_rtc_core_chk #(
    parameter int FRAC_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic              busy,
    input logic              commit,
    input logic              lock_any,
    input logic              ctl_run,
    input logic [31:0]       sec_q,
    input logic [FRAC_W-1:0] frac_q,
    input logic [31:0]       alm_sec_q,
    input logic              f_werr,
    input logic              f_alm,
    input logic              f_ovf,
    input logic              f_wdone,
    input logic              f_widle
);
    localparam logic [FRAC_W-1:0] FMAX = '1;

    p_busy_write_err_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr <= 3'd4) && busy) |=> f_werr);

    p_hold_when_stopped_r3: assert property (@(posedge clk) disable iff (rst)
        (!ctl_run && !commit) |=> ($stable(sec_q) && $stable(frac_q)));

    p_commit_flags_r6: assert property (@(posedge clk) disable iff (rst)
        commit |=> (f_wdone && f_widle && !busy));

    p_lock_refuse_r9: assert property (@(posedge clk) disable iff (rst)
        (lock_any && !busy && wr_en && (addr == 3'd0)) |=> (!busy && f_werr));

    p_alarm_off_r5: assert property (@(posedge clk) disable iff (rst)
        (alm_sec_q == 32'hFFFF_FFFF) |=> !$rose(f_alm));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl_run && tick_en && !commit && (sec_q == 32'hFFFF_FFFF) && (frac_q == FMAX))
        |=> ((sec_q == 32'd0) && f_ovf));
endmodule

bind sec_rtc_core sec_rtc_core_chk #(.FRAC_W(FRAC_W)) chk_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
    .busy(busy), .commit(commit), .lock_any(lock_any), .ctl_run(ctl_run),
    .sec_q(sec_q), .frac_q(frac_q), .alm_sec_q(alm_sec_q),
    .f_werr(flg.werr), .f_alm(flg.alm), .f_ovf(flg.ovf),
    .f_wdone(flg.wdone), .f_widle(flg.widle)
);

// File: tb/sec_rtc_core_tb_top.sv
`timescale 1ns/1ps
module sec_rtc_core_tb_top;
    localparam int FW  = 3;
    localparam int TPS = 1 << FW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0, viol_in = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sec_rtc_core #(.FRAC_W(FW), .BUSY_TICKS(4)) dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .viol_in(viol_in),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] exp_rst [8];
        int total;
        exp_rst = '{32'd0, 32'd0, 32'hFFFF_FFFF, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0};
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values and offset map
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 reset offset %0d", a), v, exp_rst[a]);
        end
        chk("R11 irq after reset", {31'd0, irq}, 32'd0);

        // R3: stopped counter ignores ticks
        tick(10);
        rd(3'd1, v); chk("R3 stopped frac", v, 32'd0);
        rd(3'd0, v); chk("R3 stopped sec", v, 32'd0);

        // R2: deferred commit on the fourth tick
        wr(3'd0, 32'hFFFF_FFFE);
        rd(3'd5, v); chk("R2 busy set", v, 32'h400);
        tick(3);
        rd(3'd5, v); chk("R2 busy after 3 ticks", v, 32'h400);
        rd(3'd0, v); chk("R2 not yet applied", v, 32'd0);
        tick(1);
        rd(3'd5, v); chk("R6 done and idle flags", v, 32'h300);
        rd(3'd0, v); chk("R2 sec applied", v, 32'hFFFF_FFFE);
        wr(3'd5, 32'h300);
        rd(3'd5, v); chk("R8 w1c status", v, 32'd0);

        wr(3'd1, 32'd5); tick(4);
        rd(3'd1, v); chk("R2 frac applied", v, 32'd5);
        wr(3'd4, 32'h8); tick(4);
        rd(3'd4, v); chk("R2 ctrl applied", v, 32'h8);
        rd(3'd1, v); chk("R3 no advance before run lands", v, 32'd5);
        wr(3'd5, 32'h300);

        // R3/R4/R5: through the seconds wrap, alarm disabled
        for (int i = 1; i <= 3; i++) begin
            tick(1);
            rd(3'd1, v); chk("R3 frac step", v, 32'((5 + i) % TPS));
        end
        rd(3'd0, v); chk("R3 carry into sec", v, 32'hFFFF_FFFF);
        tick(TPS - 1);
        rd(3'd5, v); chk("R4 no early overflow", v & 32'h4, 32'd0);
        tick(1);
        rd(3'd0, v); chk("R4 sec wrapped", v, 32'd0);
        rd(3'd5, v); chk("R4 overflow flag", v & 32'h4, 32'h4);
        chk("R5 disabled alarm quiet", v & 32'h10, 32'd0);
        wr(3'd5, 32'h4);
        rd(3'd5, v); chk("R8 overflow cleared", v & 32'h4, 32'd0);

        // R3: arithmetic sweep
        for (int i = 1; i <= 20; i++) begin
            tick(1);
            rd(3'd0, v); chk("R3 sweep sec", v, 32'(i / TPS));
            rd(3'd1, v); chk("R3 sweep frac", v, 32'(i % TPS));
        end

        // R5/R11: alarm at sec 4 sub-second 0
        total = 20;
        wr(3'd3, 32'd0); tick(4); total += 4;
        wr(3'd2, 32'd4); tick(4); total += 4;
        wr(3'd5, 32'h300);
        wr(3'd6, 32'h10);
        tick(4 * TPS - total - 1);
        rd(3'd5, v); chk("R5 alarm not early", v & 32'h10, 32'd0);
        chk("R11 irq quiet", {31'd0, irq}, 32'd0);
        tick(1);
        rd(3'd5, v); chk("R5 alarm match", v & 32'h10, 32'h10);
        chk("R11 irq alarm", {31'd0, irq}, 32'd1);
        wr(3'd5, 32'h10);
        chk("R8 alarm cleared irq", {31'd0, irq}, 32'd0);

        // R7: write during busy discarded
        wr(3'd2, 32'h100);
        wr(3'd2, 32'h55);
        rd(3'd5, v); chk("R7 error flag", v & 32'h80, 32'h80);
        tick(4);
        rd(3'd2, v); chk("R7 second write discarded", v, 32'h100);
        wr(3'd5, 32'h380);

        // R12: seconds commit freezes sub-second on that tick (frac 4 now)
        wr(3'd0, 32'h40); tick(4);
        rd(3'd0, v); chk("R12 sec replaced", v, 32'h40);
        rd(3'd1, v); chk("R12 frac no advance", v, 32'd7);

        // R6/R11: idle interrupt
        wr(3'd5, 32'h300);
        wr(3'd6, 32'h200);
        wr(3'd3, 32'd0); tick(4);
        chk("R11 irq on idle", {31'd0, irq}, 32'd1);
        wr(3'd5, 32'h200);
        chk("R11 irq idle cleared", {31'd0, irq}, 32'd0);

        // R10: violation flag
        wr(3'd6, 32'h1);
        @(negedge clk); viol_in = 1'b1;
        @(negedge clk); viol_in = 1'b0;
        rd(3'd5, v); chk("R10 violation flag", v & 32'h1, 32'h1);
        chk("R11 irq on violation", {31'd0, irq}, 32'd1);
        wr(3'd5, 32'h1);
        chk("R8 violation cleared", {31'd0, irq}, 32'd0);

        // R9: locks
        wr(3'd4, 32'h0002_0008); tick(4);
        rd(3'd4, v); chk("R9 lock set", v, 32'h0002_0008);
        wr(3'd5, 32'h380);
        wr(3'd0, 32'h1234);
        rd(3'd5, v); chk("R9 refused no busy", v & 32'h480, 32'h80);
        rd(3'd0, v); chk("R9 sec untouched", v, 32'h41);
        wr(3'd5, 32'h80);
        wr(3'd4, 32'h0002_0000);
        rd(3'd5, v); chk("R9 run change refused", v & 32'h480, 32'h80);
        wr(3'd5, 32'h80);
        wr(3'd4, 32'h8); tick(4);
        rd(3'd4, v); chk("R9 lock sticky", v, 32'h0002_0008);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule